// File: doc/BRIEF.md
# Masked Address Range Decoder

This block sorts the read and write addresses of a bus master into a set of programmable address ranges. Each range is a pair of 64-bit registers: a base and a mask. An address falls in a range when the address ANDed with the mask equals the base. Only bits [63:6] take part in that comparison, so ranges sit on 64-byte lines. Bits [3:0] of a pair carry optional checks on the request's protection attributes and on its direction.

The read-address and write-address channels are decoded side by side, each on its own. Each channel returns a registered result one cycle after its strobe: a range index, a hit flag and an error flag. An address that matches no range gives an error. An address that matches more than one range is a programming fault. It sets a sticky interrupt that software clears through a status register.

A parameter makes the pairs either writable or fixed at values supplied when the block is built.

Top module: `brm_decoder`

## Requirements
- R1: An address hits range i when (addr[63:6] & mask[63:6]) equals base[63:6]. Address bits [5:0] never affect the result.
- R2: When no range hits, the result has err=1 and hit=0. On a hit, err=0 and hit=1. The index is never at or above NUM_RANGES while hit is 1.
- R3: The request attribute vector is {dir, prot[2], prot[1], prot[0]}. Here prot[0] marks privileged, prot[1] marks non-secure and prot[2] marks instruction. dir is 1 on the read channel and 0 on the write channel. For each k in 0..3 with mask[k]=1, a range hits only if attribute bit k equals base[k].
- R4: A channel's result valid goes high exactly one clock after that channel's strobe, and only then.
- R5: When two or more ranges hit, the result reports the lowest hitting index with hit=1, and the interrupt rises on the next clock.
- R6: The interrupt stays high until a register write to the status address with wdata[0]=1. In a cycle where a new multiple hit and a clear coincide, the interrupt stays set.
- R7: After reset every mask reads 64'h0000_0FFF_FFC0_0000 (line field 0x3FFFFF0000, attribute bits zero). Every base reads its INIT_BASE slice. The interrupt and both result valids are 0.
- R8: Register map (REG_AW = IDX_W+2 bits). The MSB set selects the status register, whose bit 0 reads the interrupt. Otherwise reg_addr[IDX_W:1] is the range and reg_addr[0] picks base (0) or mask (1). All 64 bits of a pair are writable and read back unchanged, through a combinational read.
- R9: With PROGRAMMABLE=0, writes to the base and mask addresses are ignored. Reads and decoding use INIT_BASE and INIT_MASK.
- R10: Read and write channels decode in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read address strobe |
| rd_addr | input | 64 | Read address |
| rd_prot | input | 3 | Read protection attributes |
| wr_valid | input | 1 | Write address strobe |
| wr_addr | input | 64 | Write address |
| wr_prot | input | 3 | Write protection attributes |
| rd_res_valid | output | 1 | Read result valid |
| rd_res_idx | output | IDX_W | Read matching range |
| rd_res_hit | output | 1 | Read hit |
| rd_res_err | output | 1 | Read decode error |
| wr_res_valid | output | 1 | Write result valid |
| wr_res_idx | output | IDX_W | Write matching range |
| wr_res_hit | output | 1 | Write hit |
| wr_res_err | output | 1 | Write decode error |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | REG_AW | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| multi_irq | output | 1 | Sticky multiple-match interrupt |

## Verification
The assertions assume that the reset is held for at least one clock edge. They also assume that strobes, prot and the register inputs are stable around the rising edge.

The decoder does not repair a base that has 1 bits where its mask is 0. The stimulus therefore only programs bases that are already masked. It also keeps all register writes apart from decode strobes, except in the deliberate overlap cases.

The assertions do not depend on how ranges overlap. The bench creates an overlap on purpose, and only in the multiple-match case.

// File: rtl/brm_pkg.sv
package brm_pkg;
   localparam int unsigned WORD_W   = 64;
   localparam int unsigned LINE_LSB = 6;
   localparam int unsigned ATTR_N   = 4;
   localparam logic [WORD_W-1:0] MASK_RST = 64'h0000_0FFF_FFC0_0000;

   // attribute vector: {dir, instruction, non-secure, privileged}
   function automatic logic [ATTR_N-1:0] pack_attr(input logic is_read, input logic [2:0] prot);
      return {is_read, prot};
   endfunction
endpackage

// File: rtl/brm_range_cmp.sv
module brm_range_cmp
   import brm_pkg::*;
(
   input  logic [WORD_W-1:0] addr,
   input  logic [ATTR_N-1:0] attr,
   input  logic [WORD_W-1:0] base,
   input  logic [WORD_W-1:0] mask,
   output logic              hit
);
   logic line_ok;
   logic [ATTR_N-1:0] attr_bad;

   assign line_ok  = ((addr[WORD_W-1:LINE_LSB] & mask[WORD_W-1:LINE_LSB])
                      == base[WORD_W-1:LINE_LSB]);
   assign attr_bad = mask[ATTR_N-1:0] & (attr ^ base[ATTR_N-1:0]);
   assign hit      = line_ok && (attr_bad == '0);
endmodule

// File: rtl/brm_channel.sv
module brm_channel
   import brm_pkg::*;
#(
   parameter int unsigned NUM_RANGES = 4,
   parameter bit          IS_READ    = 1'b1,
   localparam int unsigned IDX_W     = $clog2(NUM_RANGES)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 req_valid,
   input  logic [WORD_W-1:0]                    req_addr,
   input  logic [2:0]                           req_prot,
   input  logic [NUM_RANGES-1:0][WORD_W-1:0]    base_q,
   input  logic [NUM_RANGES-1:0][WORD_W-1:0]    mask_q,
   output logic                                 res_valid,
   output logic [IDX_W-1:0]                     res_idx,
   output logic                                 res_hit,
   output logic                                 res_err,
   output logic                                 multi
);
   logic [NUM_RANGES-1:0] hit_vec;
   logic [ATTR_N-1:0]     attr;
   logic [IDX_W-1:0]      first_idx;

   assign attr = pack_attr(IS_READ, req_prot);

   for (genvar r = 0; r < NUM_RANGES; r++) begin : g_cmp
      brm_range_cmp u_cmp (
         .addr (req_addr),
         .attr (attr),
         .base (base_q[r]),
         .mask (mask_q[r]),
         .hit  (hit_vec[r])
      );
   end

   always_comb begin
      first_idx = '0;
      for (int r = NUM_RANGES - 1; r >= 0; r--) begin
         if (hit_vec[r]) first_idx = IDX_W'(r);
      end
   end

   assign multi = req_valid && ($countones(hit_vec) > 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_idx   <= '0;
         res_hit   <= 1'b0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_idx <= first_idx;
            res_hit <= |hit_vec;
            res_err <= ~|hit_vec;
         end
      end
   end
endmodule

// File: rtl/brm_regs.sv
module brm_regs
   import brm_pkg::*;
#(
   parameter int unsigned NUM_RANGES   = 4,
   parameter bit          PROGRAMMABLE = 1'b1,
   parameter logic [NUM_RANGES*WORD_W-1:0] INIT_BASE = '0,
   parameter logic [NUM_RANGES*WORD_W-1:0] INIT_MASK = {NUM_RANGES{MASK_RST}},
   localparam int unsigned IDX_W  = $clog2(NUM_RANGES),
   localparam int unsigned REG_AW = IDX_W + 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [REG_AW-1:0]                 reg_addr,
   input  logic [WORD_W-1:0]                 reg_wdata,
   output logic [WORD_W-1:0]                 reg_rdata,
   input  logic                              set_multi,
   output logic                              multi_irq,
   output logic [NUM_RANGES-1:0][WORD_W-1:0] base_q,
   output logic [NUM_RANGES-1:0][WORD_W-1:0] mask_q
);
   logic              sel_status;
   logic [IDX_W-1:0]  sel_range;
   logic              sel_mask;
   logic              clr_irq;

   assign sel_status = reg_addr[REG_AW-1];
   assign sel_range  = reg_addr[IDX_W:1];
   assign sel_mask   = reg_addr[0];
   assign clr_irq    = reg_we && sel_status && reg_wdata[0];

   if (PROGRAMMABLE) begin : g_rw
      for (genvar r = 0; r < NUM_RANGES; r++) begin : g_pair
         logic wr_this;
         assign wr_this = reg_we && !sel_status && (sel_range == IDX_W'(r));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q[r] <= INIT_BASE[r*WORD_W +: WORD_W];
               mask_q[r] <= MASK_RST;
            end else if (wr_this) begin
               if (sel_mask) mask_q[r] <= reg_wdata;
               else          base_q[r] <= reg_wdata;
            end
         end
      end
   end else begin : g_ro
      for (genvar r = 0; r < NUM_RANGES; r++) begin : g_pair
         assign base_q[r] = INIT_BASE[r*WORD_W +: WORD_W];
         assign mask_q[r] = INIT_MASK[r*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         multi_irq <= 1'b0;
      else if (set_multi) multi_irq <= 1'b1;
      else if (clr_irq)   multi_irq <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_status) begin
         reg_rdata[0] = multi_irq;
      end else begin
         for (int r = 0; r < NUM_RANGES; r++) begin
            if (sel_range == IDX_W'(r))
               reg_rdata = sel_mask ? mask_q[r] : base_q[r];
         end
      end
   end
endmodule

// File: rtl/brm_decoder.sv
module brm_decoder
   import brm_pkg::*;
#(
   parameter int unsigned NUM_RANGES   = 4,
   parameter bit          PROGRAMMABLE = 1'b1,
   parameter logic [NUM_RANGES*WORD_W-1:0] INIT_BASE = '0,
   parameter logic [NUM_RANGES*WORD_W-1:0] INIT_MASK = {NUM_RANGES{MASK_RST}},
   localparam int unsigned IDX_W  = $clog2(NUM_RANGES),
   localparam int unsigned REG_AW = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [63:0]       rd_addr,
   input  logic [2:0]        rd_prot,
   input  logic              wr_valid,
   input  logic [63:0]       wr_addr,
   input  logic [2:0]        wr_prot,
   output logic              rd_res_valid,
   output logic [IDX_W-1:0]  rd_res_idx,
   output logic              rd_res_hit,
   output logic              rd_res_err,
   output logic              wr_res_valid,
   output logic [IDX_W-1:0]  wr_res_idx,
   output logic              wr_res_hit,
   output logic              wr_res_err,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   output logic              multi_irq
);
   if (NUM_RANGES < 2) begin : g_bad_n
      $error("brm_decoder: NUM_RANGES must be at least 2");
   end
   if (WORD_W != 64) begin : g_bad_w
      $error("brm_decoder: register width must be 64");
   end

   logic [NUM_RANGES-1:0][WORD_W-1:0] base_q;
   logic [NUM_RANGES-1:0][WORD_W-1:0] mask_q;
   logic rd_multi, wr_multi;

   brm_regs #(
      .NUM_RANGES   (NUM_RANGES),
      .PROGRAMMABLE (PROGRAMMABLE),
      .INIT_BASE    (INIT_BASE),
      .INIT_MASK    (INIT_MASK)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .set_multi (rd_multi | wr_multi),
      .multi_irq (multi_irq),
      .base_q    (base_q),
      .mask_q    (mask_q)
   );

   brm_channel #(.NUM_RANGES(NUM_RANGES), .IS_READ(1'b1)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (rd_valid),
      .req_addr  (rd_addr),
      .req_prot  (rd_prot),
      .base_q    (base_q),
      .mask_q    (mask_q),
      .res_valid (rd_res_valid),
      .res_idx   (rd_res_idx),
      .res_hit   (rd_res_hit),
      .res_err   (rd_res_err),
      .multi     (rd_multi)
   );

   brm_channel #(.NUM_RANGES(NUM_RANGES), .IS_READ(1'b0)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (wr_valid),
      .req_addr  (wr_addr),
      .req_prot  (wr_prot),
      .base_q    (base_q),
      .mask_q    (mask_q),
      .res_valid (wr_res_valid),
      .res_idx   (wr_res_idx),
      .res_hit   (wr_res_hit),
      .res_err   (wr_res_err),
      .multi     (wr_multi)
   );
endmodule

// File: rtl/brm_decoder_chk.sv
module brm_decoder_chk #(
   parameter int unsigned NUM_RANGES = 4,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned REG_AW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid,
   input logic              wr_valid,
   input logic              rd_res_valid,
   input logic [IDX_W-1:0]  rd_res_idx,
   input logic              rd_res_hit,
   input logic              rd_res_err,
   input logic              wr_res_valid,
   input logic [IDX_W-1:0]  wr_res_idx,
   input logic              wr_res_hit,
   input logic              wr_res_err,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [63:0]       reg_wdata,
   input logic              multi_irq
);
   logic clr_req;
   assign clr_req = reg_we && reg_addr[REG_AW-1] && reg_wdata[0];

   assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_res_valid);
   assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !rd_res_valid);
   assert_wr_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> wr_res_valid);
   assert_wr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> !wr_res_valid);
   assert_rd_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_res_valid |-> (rd_res_hit != rd_res_err));
   assert_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_res_valid |-> (wr_res_hit != wr_res_err));
   assert_rd_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_res_valid && rd_res_hit) |-> (32'(rd_res_idx) < NUM_RANGES));
   assert_wr_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_res_valid && wr_res_hit) |-> (32'(wr_res_idx) < NUM_RANGES));
   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (multi_irq && !clr_req) |=> multi_irq);
   assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(multi_irq) |-> $past(clr_req));
endmodule

bind brm_decoder brm_decoder_chk #(
   .NUM_RANGES (NUM_RANGES),
   .IDX_W      (IDX_W),
   .REG_AW     (REG_AW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_valid     (rd_valid),
   .wr_valid     (wr_valid),
   .rd_res_valid (rd_res_valid),
   .rd_res_idx   (rd_res_idx),
   .rd_res_hit   (rd_res_hit),
   .rd_res_err   (rd_res_err),
   .wr_res_valid (wr_res_valid),
   .wr_res_idx   (wr_res_idx),
   .wr_res_hit   (wr_res_hit),
   .wr_res_err   (wr_res_err),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .multi_irq    (multi_irq)
);

// File: tb/brm_decoder_test.sv
module brm_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] M256 = 64'hFFFF_FFFF_F000_0000;
   localparam logic [63:0] M16  = 64'hFFFF_FFFF_FF00_0000;
   localparam logic [63:0] M1G  = 64'hFFFF_FFFF_C000_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   logic        rd_valid = 0, wr_valid = 0, reg_we = 0;
   logic [63:0] rd_addr = '0, wr_addr = '0, reg_wdata = '0;
   logic [2:0]  rd_prot = '0, wr_prot = '0;
   logic [3:0]  reg_addr = '0;
   logic        rd_res_valid, rd_res_hit, rd_res_err;
   logic        wr_res_valid, wr_res_hit, wr_res_err;
   logic [1:0]  rd_res_idx, wr_res_idx;
   logic [63:0] reg_rdata;
   logic        multi_irq;

   brm_decoder #(.NUM_RANGES(4), .PROGRAMMABLE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_prot(rd_prot),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_prot(wr_prot),
      .rd_res_valid(rd_res_valid), .rd_res_idx(rd_res_idx),
      .rd_res_hit(rd_res_hit), .rd_res_err(rd_res_err),
      .wr_res_valid(wr_res_valid), .wr_res_idx(wr_res_idx),
      .wr_res_hit(wr_res_hit), .wr_res_err(wr_res_err),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .multi_irq(multi_irq));

   // fixed-value instance, two ranges
   logic        ro_valid = 0, ro_we = 0;
   logic [63:0] ro_addr = '0, ro_wdata = '0;
   logic [2:0]  ro_reg_addr = '0;
   logic        ro_res_valid, ro_res_hit, ro_res_err, ro_irq;
   logic        ro_wv, ro_wh, ro_we_err;
   logic [0:0]  ro_res_idx, ro_widx;
   logic [63:0] ro_rdata;

   brm_decoder #(.NUM_RANGES(2), .PROGRAMMABLE(1'b0),
      .INIT_BASE({64'h0000_0000_8000_0000, 64'h0000_0000_4000_0000}),
      .INIT_MASK({M1G, M1G})) uut_ro (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(ro_valid), .rd_addr(ro_addr), .rd_prot(3'b000),
      .wr_valid(1'b0), .wr_addr(64'h0), .wr_prot(3'b000),
      .rd_res_valid(ro_res_valid), .rd_res_idx(ro_res_idx),
      .rd_res_hit(ro_res_hit), .rd_res_err(ro_res_err),
      .wr_res_valid(ro_wv), .wr_res_idx(ro_widx),
      .wr_res_hit(ro_wh), .wr_res_err(ro_we_err),
      .reg_we(ro_we), .reg_addr(ro_reg_addr), .reg_wdata(ro_wdata),
      .reg_rdata(ro_rdata), .multi_irq(ro_irq));

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // strobe both channels for one cycle; results sampled at the following negedge
   task automatic decode(input bit rv, input logic [63:0] ra, input logic [2:0] rp,
                         input bit wv, input logic [63:0] wa, input logic [2:0] wp);
      @(negedge clk);
      rd_valid = rv; rd_addr = ra; rd_prot = rp;
      wr_valid = wv; wr_addr = wa; wr_prot = wp;
      @(negedge clk);
      rd_valid = 0; wr_valid = 0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      chk("R7", "irq after reset", 64'(multi_irq), 64'h0);
      chk("R7", "rd valid after reset", 64'(rd_res_valid), 64'h0);
      rd_reg(4'b0011, d); chk("R7", "mask1 reset", d, 64'h0000_0FFF_FFC0_0000);
      rd_reg(4'b0100, d); chk("R7", "base2 reset", d, 64'h0);
   endtask

   task automatic t_program();
      logic [63:0] d;
      wr_reg(4'b0000, 64'h1000_0000);          wr_reg(4'b0001, M256);
      wr_reg(4'b0010, 64'h2000_0000);          wr_reg(4'b0011, M256 | 64'h2);
      wr_reg(4'b0100, 64'h3000_0000 | 64'h8); wr_reg(4'b0101, M256 | 64'h8);
      wr_reg(4'b0110, 64'h1000_0000);          wr_reg(4'b0111, M16);
      rd_reg(4'b0101, d); chk("R8", "mask2 readback", d, M256 | 64'h8);
      rd_reg(4'b0100, d); chk("R8", "base2 readback", d, 64'h3000_0008);
   endtask

   task automatic t_match();
      decode(1, 64'h1800_0040, 3'b000, 0, '0, '0);
      chk("R1", "rd hit range0", {rd_res_valid, rd_res_hit, rd_res_err, rd_res_idx}, 5'b11000);
      decode(1, 64'h1800_003F, 3'b101, 0, '0, '0);
      chk("R1", "low bits ignored", {rd_res_hit, rd_res_idx}, 3'b100);
      decode(1, 64'h5000_0000, 3'b000, 0, '0, '0);
      chk("R2", "no match", {rd_res_hit, rd_res_err}, 2'b01);
      decode(1, 64'h1_1800_0000, 3'b000, 0, '0, '0);
      chk("R2", "upper bit breaks match", {rd_res_hit, rd_res_err}, 2'b01);
   endtask

   task automatic t_attr();
      decode(1, 64'h2000_0000, 3'b001, 0, '0, '0);
      chk("R3", "secure passes", {rd_res_hit, rd_res_idx}, 3'b101);
      decode(1, 64'h2000_0000, 3'b010, 0, '0, '0);
      chk("R3", "non-secure rejected", {rd_res_hit, rd_res_err}, 2'b01);
      decode(1, 64'h3000_0100, 3'b000, 1, 64'h3000_0100, 3'b000);
      chk("R3", "read allowed range2", {rd_res_hit, rd_res_idx}, 3'b110);
      chk("R3", "write refused range2", {wr_res_hit, wr_res_err}, 2'b01);
   endtask

   task automatic t_dual();
      decode(1, 64'h2000_0000, 3'b000, 1, 64'h1800_0000, 3'b000);
      chk("R10", "rd idx1", {rd_res_valid, rd_res_hit, rd_res_idx}, 4'b1101);
      chk("R10", "wr idx0", {wr_res_valid, wr_res_hit, wr_res_idx}, 4'b1100);
      @(negedge clk);
      chk("R4", "valids drop", {rd_res_valid, wr_res_valid}, 2'b00);
   endtask

   task automatic t_multi();
      logic [63:0] d;
      chk("R5", "irq idle before", 64'(multi_irq), 64'h0);
      decode(0, '0, '0, 1, 64'h1000_1000, 3'b000);
      chk("R5", "lowest index on overlap", {wr_res_hit, wr_res_idx}, 3'b100);
      chk("R5", "irq raised", 64'(multi_irq), 64'h1);
      repeat (3) @(negedge clk);
      chk("R6", "irq holds", 64'(multi_irq), 64'h1);
      wr_reg(4'b1000, 64'h0);
      chk("R6", "write 0 keeps irq", 64'(multi_irq), 64'h1);
      rd_reg(4'b1000, d); chk("R6", "status reads irq", d, 64'h1);
      wr_reg(4'b1000, 64'h1);
      chk("R6", "write 1 clears irq", 64'(multi_irq), 64'h0);
      // clear and new overlap in the same cycle: set wins
      @(negedge clk);
      reg_we = 1; reg_addr = 4'b1000; reg_wdata = 64'h1;
      rd_valid = 1; rd_addr = 64'h1000_0000; rd_prot = 3'b000;
      @(negedge clk);
      reg_we = 0; rd_valid = 0;
      chk("R6", "set beats clear", 64'(multi_irq), 64'h1);
      wr_reg(4'b1000, 64'h1);
   endtask

   task automatic t_fixed();
      @(negedge clk);
      ro_we = 1; ro_reg_addr = 3'b000; ro_wdata = 64'hDEAD_0000;
      @(negedge clk);
      ro_we = 0; ro_reg_addr = 3'b000;
      #1 chk("R9", "fixed base ignores write", ro_rdata, 64'h4000_0000);
      ro_reg_addr = 3'b011;
      #1 chk("R9", "fixed mask1", ro_rdata, M1G);
      @(negedge clk);
      ro_valid = 1; ro_addr = 64'h8000_1000;
      @(negedge clk);
      ro_valid = 0;
      chk("R9", "fixed decode idx1", {ro_res_hit, ro_res_idx}, 2'b11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_program();
      t_match();
      t_attr();
      t_dual();
      t_multi();
      t_fixed();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule